// File: doc/BRIEF.md
# Interrupt masking unit with timed disable

This block decides which pending interrupt request lines may reach the processor core in the current cycle. Each request line carries a priority level. A line passes only when its own enable bit is set and its level is strictly above the CPU priority level. It must also survive a timed disable window. Software opens that window with a disable command that loads a countdown of instruction cycles. While the countdown is nonzero, every line below the top priority level is held off. Trap inputs bypass all of this and always raise the take flag.

The countdown falls by one on each instruction-retire strobe and stops at zero. It can be cut short in two ways: by issuing a disable command with a count of zero, or by writing the countdown register directly while the window is open. A direct write made while no window is open is ignored. The outputs are combinational from the registered enable and countdown state together with the current requests. Priority arbitration between the passing lines belongs to logic further downstream.

Top module: `irq_mask_unit`

## Requirements
- R1: Writing the enable register (`en_we_i` high) loads `en_wdata_i` at the next clock edge. Bit i at 1 lets request line i pass, and bit i at 0 blocks it. With no write, the enables hold their value.
- R2: Reset clears all enable bits and the countdown, so no request line passes after reset.
- R3: A disable command (`dis_cmd_i` high) loads `dis_cnt_i` into the countdown at the next edge. While the countdown is nonzero, every line with a level below 7 is blocked.
- R4: The largest count is 0x3FFF, and the countdown is 14 bits wide. A load of 0x3FFF keeps the window open for exactly 16383 retire strobes.
- R5: The countdown falls by one on each cycle with `retire_i` high and stays unchanged on cycles without it. It saturates at zero.
- R6: A disable command with a count of 0 ends the window at the next edge.
- R7: A direct countdown write (`cnt_we_i`) is taken only while the window is open (countdown nonzero after a disable command). Writing 0 ends the window, and writing a nonzero value replaces the count. A write made while the countdown is zero is ignored.
- R8: Lines at level 7 are not blocked by the countdown. They are blocked only when the CPU level is 7.
- R9: A line passes only if its level is strictly greater than `cpu_lvl_i`.
- R10: Any asserted trap input raises `take_o` in the same cycle, regardless of enables, countdown or CPU level.
- R11: A disable command has priority over a direct countdown write and over a retire decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_IRQ | Pending request lines |
| irq_lvl_i | input | NUM_IRQ*LVL_W | Level of each line, line i in bits [i*LVL_W +: LVL_W] |
| retire_i | input | 1 | One instruction retired this cycle |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_IRQ | Enable register write data |
| cnt_we_i | input | 1 | Direct countdown write strobe |
| cnt_wdata_i | input | CNT_W | Direct countdown write data |
| dis_cmd_i | input | 1 | Timed-disable command |
| dis_cnt_i | input | CNT_W | Cycle count carried by the command |
| cpu_lvl_i | input | LVL_W | Current CPU priority level |
| trap_i | input | NUM_TRAP | Unmaskable trap inputs |
| irq_pass_o | output | NUM_IRQ | Requests that survive masking |
| take_o | output | 1 | A request or trap should be taken |

## Verification
The bench keeps its own reference model and compares both outputs against it on every cycle. The directed patterns cover:
- Enable words in alternating patterns, which separate per-bit gating from whole-word gating.
- Requests at, just above and just below the CPU level, which separate a strict comparison from a non-strict one.
- A window at level 7 with a level-7 line inside it, which shows whether the top-level exemption follows the line's level or the CPU's.
- Countdown writes made inside and outside a window, and commands that collide with writes and retires, which expose the update priority.

A randomised phase mixes every input to reach combinations the directed cases leave out. A full 0x3FFF window, retired once per cycle, checks the counter's width and its exact length.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned CNT_W   = 14;
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_LOAD,
    CNT_WRITE,
    CNT_DEC
  } cnt_op_e;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  output logic [NUM_IRQ-1:0] en_o
);
  logic [NUM_IRQ-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q)); // R1
  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> en_q == $past(wdata_i)); // R1
endmodule

// File: rtl/irq_disi_timer.sv
module irq_disi_timer
  import irq_mask_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_i,
  input  logic [CW-1:0] cmd_cnt_i,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          retire_i,
  output logic          active_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          open_w;
  cnt_op_e       op;

  assign open_w = armed_q && (cnt_q != '0);

  // command > direct write > retire decrement
  always_comb begin
    if (cmd_i)                op = CNT_LOAD;
    else if (we_i && open_w)  op = CNT_WRITE;
    else if (retire_i && open_w) op = CNT_DEC;
    else                      op = CNT_HOLD;
  end

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    unique case (op)
      CNT_LOAD:  cnt_d = cmd_cnt_i;
      CNT_WRITE: cnt_d = wdata_i;
      CNT_DEC:   cnt_d = cnt_q - 1'b1;
      default:   cnt_d = cnt_q;
    endcase
    if (op == CNT_LOAD)     armed_d = 1'b1;
    else if (cnt_d == '0)   armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign active_o = cnt_q != '0;

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> cnt_q == $past(cmd_cnt_i)); // R11
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i && !we_i && retire_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i && !retire_i && !we_i) |=> $stable(cnt_q)); // R5
  AST_CNT_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i && cnt_q == '0) |=> cnt_q == '0); // R7
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned LW      = LVL_W
) (
  input  logic [NUM_IRQ-1:0]    req_i,
  input  logic [NUM_IRQ*LW-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0]    en_i,
  input  logic [LW-1:0]         cpu_lvl_i,
  input  logic                  win_i,
  output logic [NUM_IRQ-1:0]    pass_o
);
  localparam logic [LW-1:0] TOP = '1;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic [LW-1:0] lvl;
    logic          above, exempt;
    assign lvl       = lvl_i[i*LW +: LW];
    assign above     = lvl > cpu_lvl_i;
    assign exempt    = lvl == TOP;
    assign pass_o[i] = req_i[i] && en_i[i] && above && (!win_i || exempt);
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 8,
  parameter int unsigned NUM_TRAP = 2,
  parameter int unsigned LW       = LVL_W,
  parameter int unsigned CW       = CNT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_IRQ-1:0]    irq_req_i,
  input  logic [NUM_IRQ*LW-1:0] irq_lvl_i,
  input  logic                  retire_i,
  input  logic                  en_we_i,
  input  logic [NUM_IRQ-1:0]    en_wdata_i,
  input  logic                  cnt_we_i,
  input  logic [CW-1:0]         cnt_wdata_i,
  input  logic                  dis_cmd_i,
  input  logic [CW-1:0]         dis_cnt_i,
  input  logic [LW-1:0]         cpu_lvl_i,
  input  logic [NUM_TRAP-1:0]   trap_i,
  output logic [NUM_IRQ-1:0]    irq_pass_o,
  output logic                  take_o
);
  logic [NUM_IRQ-1:0] en_w;
  logic               win_w;

  irq_en_reg #(.NUM_IRQ(NUM_IRQ)) u_en (
    .clk_i, .rst_ni,
    .we_i(en_we_i), .wdata_i(en_wdata_i), .en_o(en_w)
  );

  irq_disi_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni,
    .cmd_i(dis_cmd_i), .cmd_cnt_i(dis_cnt_i),
    .we_i(cnt_we_i), .wdata_i(cnt_wdata_i),
    .retire_i, .active_o(win_w)
  );

  irq_qualify #(.NUM_IRQ(NUM_IRQ), .LW(LW)) u_q (
    .req_i(irq_req_i), .lvl_i(irq_lvl_i), .en_i(en_w),
    .cpu_lvl_i, .win_i(win_w), .pass_o(irq_pass_o)
  );

  assign take_o = (|irq_pass_o) || (|trap_i);

  AST_TRAP_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trap_i) |-> take_o); // R10
  AST_PASS_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pass_o & ~en_w) == '0); // R1
  AST_TOP_CPU_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_lvl_i == TOP_LVL) |-> irq_pass_o == '0); // R8
  AST_CMD_ZERO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_cmd_i && dis_cnt_i == '0) |=> !win_w); // R6
endmodule

// File: tb/irq_mask_unit_tb.sv
module irq_mask_unit_tb_top;
  localparam int N = 8;
  localparam int NT = 2;
  localparam int LW = 3;
  localparam int CW = 14;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, en_wd = '0, pass;
  logic [N*LW-1:0] lvl = '0;
  logic retire = 0, en_we = 0, cnt_we = 0, dcmd = 0, take;
  logic [CW-1:0] cnt_wd = '0, dcnt = '0;
  logic [LW-1:0] cpu = '0;
  logic [NT-1:0] trap = '0;

  always #4 clk = ~clk;

  irq_mask_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .irq_lvl_i(lvl),
    .retire_i(retire), .en_we_i(en_we), .en_wdata_i(en_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .dis_cmd_i(dcmd),
    .dis_cnt_i(dcnt), .cpu_lvl_i(cpu), .trap_i(trap),
    .irq_pass_o(pass), .take_o(take)
  );

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R2";

  // reference model
  bit [N-1:0] m_en = '0;
  int m_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_cnt <= 0;
    end else begin
      if (en_we) m_en <= en_wd;
      if (dcmd) m_cnt <= int'(dcnt);
      else if (cnt_we && m_cnt != 0) m_cnt <= int'(cnt_wd);
      else if (retire && m_cnt > 0) m_cnt <= m_cnt - 1;
    end
  end

  function automatic bit [N-1:0] exp_pass();
    bit [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int l;
      l = int'(lvl[i*LW +: LW]);
      r[i] = req[i] && m_en[i] && (l > int'(cpu)) && (m_cnt == 0 || l == 7);
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit [N-1:0] e;
      bit et;
      e = exp_pass();
      et = (|e) || (|trap);
      tests++;
      if (pass !== e || take !== et) begin
        fails++;
        $display("FAIL %s model: pass=%h take=%b expected pass=%h take=%b", tag, pass, take, e, et);
      end
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string t);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic all_lvl(input int l);
    for (int i = 0; i < N; i++) lvl[i*LW +: LW] = LW'(l);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    req = '1; all_lvl(5);
    repeat (2) @(posedge clk);
    @(negedge clk); chk(pass, '0, "R2 reset");
    rst_n = 1;
    tick(); @(negedge clk); chk({7'b0, take}, '0, "R2 after reset");

    tag = "R1";
    en_we = 1; en_wd = 8'hA5; tick(); en_we = 0;
    @(negedge clk); chk(pass, 8'hA5, "R1 enable A5");
    en_we = 1; en_wd = 8'h5A; tick(); en_we = 0; en_wd = '0;
    @(negedge clk); chk(pass, 8'h5A, "R1 enable 5A");
    tick(); @(negedge clk); chk(pass, 8'h5A, "R1 hold");
    en_we = 1; en_wd = '1; tick(); en_we = 0;

    tag = "R9";
    cpu = 5; tick(); @(negedge clk); chk(pass, '0, "R9 equal level");
    all_lvl(6); tick(); @(negedge clk); chk(pass, '1, "R9 one above");
    cpu = 6; all_lvl(5); tick(); @(negedge clk); chk(pass, '0, "R9 below");
    cpu = 0;

    tag = "R3";
    all_lvl(4); dcmd = 1; dcnt = 10; tick(); dcmd = 0;
    @(negedge clk); chk(pass, '0, "R3 window blocks");
    retire = 1;
    repeat (9) tick();
    @(negedge clk); chk(pass, '0, "R3 last window cycle");
    tick(); @(negedge clk); chk(pass, '1, "R3 window over");

    tag = "R5";
    retire = 0; dcmd = 1; dcnt = 3; tick(); dcmd = 0;
    repeat (5) tick();
    @(negedge clk); chk(pass, '0, "R5 no retire no decrement");
    retire = 1; repeat (3) tick(); retire = 0;
    @(negedge clk); chk(pass, '1, "R5 three retires");
    retire = 1; repeat (3) tick(); retire = 0;
    @(negedge clk); chk(pass, '1, "R5 saturate zero");

    tag = "R6";
    dcmd = 1; dcnt = 100; tick(); dcnt = 0; tick(); dcmd = 0;
    @(negedge clk); chk(pass, '1, "R6 zero command ends window");

    tag = "R7";
    cnt_we = 1; cnt_wd = 50; tick(); cnt_we = 0;
    @(negedge clk); chk(pass, '1, "R7 write while idle ignored");
    dcmd = 1; dcnt = 100; tick(); dcmd = 0;
    cnt_we = 1; cnt_wd = 0; tick(); cnt_we = 0;
    @(negedge clk); chk(pass, '1, "R7 write zero ends window");
    dcmd = 1; dcnt = 2; tick(); dcmd = 0;
    cnt_we = 1; cnt_wd = 6; tick(); cnt_we = 0;
    retire = 1; repeat (5) tick();
    @(negedge clk); chk(pass, '0, "R7 write extends window");
    tick(); retire = 0; @(negedge clk); chk(pass, '1, "R7 extended window done");

    tag = "R8";
    lvl[0 +: LW] = 3'd7; dcmd = 1; dcnt = 20; tick(); dcmd = 0;
    @(negedge clk); chk(pass, 8'h01, "R8 level 7 through window");
    cpu = 7; tick(); @(negedge clk); chk(pass, '0, "R8 cpu level 7 blocks");
    cpu = 0; dcmd = 1; dcnt = 0; tick(); dcmd = 0;

    tag = "R10";
    en_we = 1; en_wd = '0; trap = 2'b10; cpu = 7; dcmd = 1; dcnt = 9; tick();
    en_we = 0; dcmd = 0;
    @(negedge clk); chk({7'b0, take}, 8'h01, "R10 trap unmaskable");
    trap = '0; tick(); @(negedge clk); chk({7'b0, take}, '0, "R10 no trap");
    cpu = 0; en_we = 1; en_wd = '1; tick(); en_we = 0;

    tag = "R11";
    dcmd = 1; dcnt = 1; cnt_we = 1; cnt_wd = 40; retire = 1; tick();
    dcmd = 0; cnt_we = 0; retire = 0;
    @(negedge clk); chk(pass, 8'h01, "R11 command wins");
    retire = 1; tick(); retire = 0;
    @(negedge clk); chk(pass, '1, "R11 one retire ends");

    tag = "R4";
    all_lvl(1); dcmd = 1; dcnt = 14'h3FFF; tick(); dcmd = 0; retire = 1;
    repeat (16382) tick();
    @(negedge clk); chk(pass, '0, "R4 window before last retire");
    tick(); retire = 0;
    @(negedge clk); chk(pass, '1, "R4 window ends after 16383");

    tag = "R1 R3 R5 R7 R8 R9 R11 random";
    for (int k = 0; k < 400; k++) begin
      req = N'($urandom); lvl = (N*LW)'($urandom);
      cpu = LW'($urandom_range(0, 7));
      retire = 1'($urandom);
      en_we = ($urandom_range(0, 7) == 0); en_wd = N'($urandom);
      dcmd = ($urandom_range(0, 15) == 0); dcnt = CW'($urandom_range(0, 12));
      cnt_we = ($urandom_range(0, 7) == 0); cnt_wd = CW'($urandom_range(0, 8));
      trap = ($urandom_range(0, 15) == 0) ? 2'b01 : 2'b00;
      tick();
    end
    en_we = 0; dcmd = 0; cnt_we = 0; retire = 0; trap = '0;
    tick(); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule